// File: doc/BRIEF.md
# Mode-Selectable 2x Half-Band Interpolator

This block sits in a transmit path between a parallel sample source and a DAC data bus. The DAC side is clocked at the output rate. A 4-bit mode code selects one of three behaviours:

- **Low-pass interpolation.** The sample rate is doubled and the baseband image is kept.
- **Band-pass interpolation.** The sample rate is doubled and the image centred on half the output rate is kept. The baseband is rejected.
- **Pass-through.** Samples go to the DAC unfiltered, one per output clock.

Both interpolating modes use one fixed set of 35 half-band coefficients, split into two polyphase branches. The centre branch is a pure delay. Band-pass mode is obtained by negating the sign of every output sample from the multi-tap branch. This is the same as shifting the low-pass response by half the output rate.

The input is a valid/ready stream. The output is free-running: the DAC consumes one word every clock and never applies back-pressure. In the interpolating modes, `in_ready` is high on every second clock. In pass-through it is high on every clock. `in_ready` never depends on `in_valid`. If a slot offered by `in_ready` is not taken, the block still consumes a sample at that edge and treats it as zero. Any change of the mode code clears the whole datapath. Both interpolating modes therefore start from silence and share one fixed latency.

Below, the "accept edge" of a sample is the rising edge at which `in_ready` is high. "k clocks after" an accept edge means the value on `dac_data` after the k-th rising edge that follows it.

Top module: `hb_interp2x`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dac_data` is 0. Reset loads the internal mode register with code 0x0 (pass-through), so `in_ready` is high in the first cycle after reset when `mode_code` is 0x0.
- R2: With `mode_code` 0x1 (low-pass), the output is the 2x zero-stuffed input convolved with a 35-tap response, scaled by 1/32768.
  - The response is 32768 at its centre.
  - At odd distance d from the centre it is c(d): c(1)=20707, c(3)=-6488, c(5)=3424, c(7)=-1999, c(9)=1160, c(11)=-623, c(13)=287, c(15)=-93, c(17)=9.
  - It is 0 at every other distance.
  - Output index m (the m-th output of the response to the first accepted sample) appears m+13 clocks after that sample's accept edge.
- R3: With `mode_code` 0x5 (band-pass), the output equals R2 except that every output at an even index m is negated before rounding. Even-index outputs are the ones built from the multi-tap branch. The centre-tap outputs keep their sign.
- R4: In both interpolating modes, an isolated impulse of amplitude A reaches `dac_data` with value exactly A, 30 clocks after its accept edge.
- R5: In both interpolating modes, after an isolated impulse with zero input afterwards, `dac_data` is 0 from 48 clocks after the accept edge onward.
- R6: `in_ready` does not depend on `in_valid`.
  - In pass-through mode it is high on every clock.
  - In the interpolating modes it is high on alternate clocks: high in the cycle after a mode change, low in the cycle after each accept edge.
- R7: At an accept edge with `in_valid` low, the sample taken is 0 and `in_data` has no effect on any later output.
- R8: Each filtered value is rounded by adding 16384 and shifting right arithmetically by 15. It is then saturated to the signed 12-bit range -2048..2047.
- R9: Every code other than 0x1 and 0x5 (0x0 included) selects pass-through. The sample taken at an accept edge appears unchanged on `dac_data` 3 clocks later.
- R10: In a cycle where `mode_code` differs from the value it had at the previous rising edge, `in_ready` is low. That edge clears the delay line and the pipeline, so `dac_data` is 0 after it. The first accept under the new mode happens at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate (DAC) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_code | input | 4 | Mode code: 0x1 low-pass, 0x5 band-pass, any other pass-through |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block takes a sample at the next rising edge |
| in_data | input | 12 | Input sample, two's complement |
| dac_data | output | 12 | DAC word, two's complement, one per clock |

## Verification
The assertions assume that `mode_code`, `in_valid` and `in_data` change only between rising edges and are never unknown once reset is released. They also assume a mode change is detected purely from `mode_code` differing from its value at the previous edge. The pass-through data property further assumes the code has been held for four edges before it compares `dac_data` with the input taken four edges earlier.

The bench drives every input on the falling edge. It changes `mode_code` only to a value that differs from the current one, so that each scenario starts from a guaranteed flush. It also leaves junk on `in_data` whenever `in_valid` is low, so that any leak of an ignored sample shows up in the compared outputs.

// File: rtl/hb_interp2x_pkg.sv
`timescale 1ns/1ps
package hb_interp2x_pkg;

  // Coefficient format: signed, scaled so that 1.0 == 2**COEF_FRAC
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 15;

  // One side of the half-band wing: distinct nonzero taps at odd distance from centre
  localparam int WING    = 9;
  localparam int BR_TAPS = 2 * WING;      // taps in the multi-tap polyphase branch
  localparam int CTR_POS = 2 * WING - 1;  // centre index of the full prototype response

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_LPF  = 2'd1,
    MODE_BPF  = 2'd2
  } ixmode_t;

  localparam logic [3:0] CODE_LPF   = 4'h1;
  localparam logic [3:0] CODE_BPF   = 4'h5;
  localparam logic [3:0] CODE_RESET = 4'h0;

  function automatic ixmode_t decode_mode(input logic [3:0] code);
    case (code)
      CODE_LPF: return MODE_LPF;
      CODE_BPF: return MODE_BPF;
      default:  return MODE_PASS;
    endcase
  endfunction

  // Wing coefficient by index: index j sits at distance 2j+1 from the centre
  function automatic logic signed [COEF_W-1:0] wing_coef(input int j);
    case (j)
      0:       return  16'sd20707;
      1:       return -16'sd6488;
      2:       return  16'sd3424;
      3:       return -16'sd1999;
      4:       return  16'sd1160;
      5:       return -16'sd623;
      6:       return  16'sd287;
      7:       return -16'sd93;
      8:       return  16'sd9;
      default: return  16'sd0;
    endcase
  endfunction

endpackage

// File: rtl/hb_ix_ctrl.sv
`timescale 1ns/1ps
module hb_ix_ctrl
  import hb_interp2x_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_code,
  output ixmode_t    mode,
  output logic       flush,
  output logic       fir_phase,
  output logic       take
);

  logic [3:0] code_q;
  logic       ph_q;

  // Any difference from the code seen at the previous edge restarts the datapath
  assign flush = (mode_code != code_q);
  assign mode  = decode_mode(code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_RESET;
      ph_q   <= 1'b0;
    end else begin
      code_q <= mode_code;
      if (flush || mode == MODE_PASS) ph_q <= 1'b0;
      else                            ph_q <= ~ph_q;
    end
  end

  // ph_q high means the cycle right after an accept: multi-tap branch output slot
  assign fir_phase = ph_q;
  assign take      = !flush && (mode == MODE_PASS || !ph_q);

endmodule

// File: rtl/hb_ix_branch.sv
`timescale 1ns/1ps
module hb_ix_branch
  import hb_interp2x_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 34
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     shift,
  input  logic signed [DATA_W-1:0] din,
  input  logic                     fir_phase,
  input  logic                     negate_fir,
  input  logic                     bypass,
  output logic signed [ACC_W-1:0]  acc_q
);

  localparam int CTR_IDX = WING - 1;   // delay-line slot feeding the centre phase

  logic signed [DATA_W-1:0] sx   [BR_TAPS];
  logic signed [DATA_W:0]   pair [WING];

  // Input-rate delay line
  for (genvar i = 0; i < BR_TAPS; i++) begin : g_line
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sx[i] <= '0;
        else if (flush) sx[i] <= '0;
        else if (shift) sx[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sx[i] <= '0;
        else if (flush) sx[i] <= '0;
        else if (shift) sx[i] <= sx[i-1];
      end
    end
  end

  // Symmetric pre-add: tap k mirrors tap BR_TAPS-1-k
  for (genvar k = 0; k < WING; k++) begin : g_pair
    assign pair[k] = (DATA_W+1)'(sx[k]) + (DATA_W+1)'(sx[BR_TAPS-1-k]);
  end

  logic signed [ACC_W-1:0] fir_sum;
  logic signed [ACC_W-1:0] ctr_term;
  logic signed [ACC_W-1:0] byp_term;
  logic signed [ACC_W-1:0] acc_d;

  always_comb begin
    fir_sum = '0;
    for (int k = 0; k < WING; k++) begin
      // Pair k sits at prototype index 2k, i.e. distance 2(WING-1-k)+1 from the centre
      fir_sum = fir_sum + ACC_W'(pair[k]) * ACC_W'(wing_coef(WING - 1 - k));
    end
  end

  assign ctr_term = ACC_W'(sx[CTR_IDX]) <<< COEF_FRAC;
  assign byp_term = ACC_W'(sx[0]) <<< COEF_FRAC;

  always_comb begin
    if (bypass)         acc_d = byp_term;
    else if (fir_phase) acc_d = negate_fir ? -fir_sum : fir_sum;
    else                acc_d = ctr_term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (flush) acc_q <= '0;
    else            acc_q <= acc_d;
  end

endmodule

// File: rtl/hb_ix_rndsat.sv
`timescale 1ns/1ps
module hb_ix_rndsat
  import hb_interp2x_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 34
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic signed [ACC_W-1:0]  acc,
  output logic signed [DATA_W-1:0] q
);

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (COEF_FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(1 << (DATA_W - 1)));

  logic signed [ACC_W-1:0]  rnd;
  logic signed [DATA_W-1:0] q_d;

  assign rnd = (acc + HALF) >>> COEF_FRAC;

  always_comb begin
    if (rnd > MAXV)      q_d = MAXV[DATA_W-1:0];
    else if (rnd < MINV) q_d = MINV[DATA_W-1:0];
    else                 q_d = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (flush) q <= '0;
    else            q <= q_d;
  end

endmodule

// File: rtl/hb_interp2x.sv
`timescale 1ns/1ps
module hb_interp2x
  import hb_interp2x_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int LATENCY = 30
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode_code,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] dac_data
);

  localparam int ACC_W = DATA_W + COEF_W + 6;
  // Registers after the combinational sum: accumulator, round/sat, tail, output
  localparam int TAIL  = LATENCY - CTR_POS - 3;

  ixmode_t mode;
  logic    flush;
  logic    fir_phase;
  logic    take;

  hb_ix_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_code (mode_code),
    .mode      (mode),
    .flush     (flush),
    .fir_phase (fir_phase),
    .take      (take)
  );

  assign in_ready = take;

  logic signed [DATA_W-1:0] din;
  assign din = in_valid ? $signed(in_data) : '0;

  logic signed [ACC_W-1:0] acc_q;

  hb_ix_branch #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_branch (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .shift      (take),
    .din        (din),
    .fir_phase  (fir_phase),
    .negate_fir (mode == MODE_BPF),
    .bypass     (mode == MODE_PASS),
    .acc_q      (acc_q)
  );

  logic signed [DATA_W-1:0] rs_q;

  hb_ix_rndsat #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_rndsat (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .acc   (acc_q),
    .q     (rs_q)
  );

  // Alignment delay so the centre tap lands exactly on LATENCY
  logic signed [DATA_W-1:0] tail_out;

  if (TAIL > 0) begin : g_tail
    logic signed [DATA_W-1:0] tl [TAIL];
    for (genvar s = 0; s < TAIL; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tl[s] <= '0;
        else if (flush) tl[s] <= '0;
        else            tl[s] <= (s == 0) ? rs_q : tl[(s == 0) ? 0 : s - 1];
      end
    end
    assign tail_out = tl[TAIL-1];
  end else begin : g_notail
    assign tail_out = rs_q;
  end

  logic signed [DATA_W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= '0;
    else if (flush) out_q <= '0;
    else            out_q <= (mode == MODE_PASS) ? rs_q : tail_out;
  end

  assign dac_data = out_q;

endmodule

// File: rtl/hb_interp2x_chk.sv
`timescale 1ns/1ps
module hb_interp2x_chk #(
  parameter int DATA_W = 12
)(
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        mode_code,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [DATA_W-1:0] dac_data
);

  function automatic logic is_pass(input logic [3:0] c);
    return (c != 4'h1) && (c != 4'h5);
  endfunction

  // Edges since pass-through mode was last entered without a code change
  logic [3:0] prev_code;
  logic       prev_ok;
  logic [2:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code <= 4'h0;
      prev_ok   <= 1'b0;
      run       <= '0;
    end else begin
      prev_code <= mode_code;
      prev_ok   <= 1'b1;
      if (!prev_ok || mode_code != prev_code || !is_pass(mode_code)) run <= '0;
      else if (run != 3'd7)                                            run <= run + 3'd1;
    end
  end

  assert_rdy_cadence_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !is_pass(mode_code)) |=> !in_ready);

  assert_pass_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && is_pass(mode_code) && $stable(mode_code)) |-> in_ready);

  assert_chg_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(mode_code)) |-> !in_ready);

  assert_flush_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(mode_code)) |=> (dac_data == '0));

  assert_pass_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run >= 3'd4) |-> (dac_data == $past(in_valid ? in_data : '0, 4)));

endmodule

bind hb_interp2x hb_interp2x_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_code (mode_code),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .dac_data  (dac_data)
);

// File: tb/tb_hb_interp2x.sv
`timescale 1ns/1ps
module tb_hb_interp2x;

  localparam int DW = 12;

  logic          clk       = 1'b0;
  logic          rst_n     = 1'b0;
  logic [3:0]    mode_code = 4'h0;
  logic          in_valid  = 1'b0;
  logic [DW-1:0] in_data   = '0;
  wire           in_ready;
  wire  [DW-1:0] dac_data;

  always #2 clk = ~clk;   // 250 MHz

  hb_interp2x dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_code (mode_code),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .dac_data  (dac_data)
  );

  int checks = 0;
  int fails  = 0;
  int xs [0:255];
  int nx     = 0;
  bit done   = 0;

  function automatic int s12(input logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Prototype tap by index 0..34 (R2)
  function automatic int hcoef(input int n);
    int d;
    d = (n > 17) ? n - 17 : 17 - n;
    case (d)
      1:  return 20707;
      3:  return -6488;
      5:  return 3424;
      7:  return -1999;
      9:  return 1160;
      11: return -623;
      13: return 287;
      15: return -93;
      17: return 9;
      default: return 0;
    endcase
  endfunction

  function automatic int xsamp(input int j);
    if (j < 0 || j >= nx) return 0;
    return xs[j];
  endfunction

  function automatic int satr(input longint v);
    longint r;
    r = (v + 64'sd16384) >>> 15;   // R8
    if (r > 2047)  return 2047;
    if (r < -2048) return -2048;
    return int'(r);
  endfunction

  // kind: 0 pass, 1 low-pass, 2 band-pass; t = clocks after first accept edge
  function automatic int ref_out(input int t, input int kind);
    int m;
    longint acc;
    if (kind == 0) return xsamp(t - 3);          // R9
    m = t - 13;
    if (m < 0) return 0;
    if (m % 2 == 1) return xsamp((m - 17) / 2);  // centre tap
    acc = 0;
    for (int k = 0; k < 18; k++)
      acc += longint'(hcoef(2 * k)) * longint'(xsamp(m / 2 - k));
    if (kind == 2) acc = -acc;                   // R3
    return satr(acc);
  endfunction

  function automatic int pat_val(input int pat, input int i, input int amp, output bit vld);
    int pr;
    pr = ((i * 2731 + 1237) % 4096) - 2048;
    case (pat)
      0: begin vld = (i == 0); return (i == 0) ? amp : 1234; end
      1: begin vld = 1'b1; return pr; end
      2: begin vld = 1'b1; return ((i / 6) % 2 == 0) ? 2047 : -2048; end
      default: begin vld = (i % 3 != 2); return pr; end
    endcase
  endfunction

  task automatic drive(input int pat, input int amp);
    bit v;
    int d;
    d = pat_val(pat, nx, amp, v);
    in_valid = v;
    in_data  = d[DW-1:0];
    xs[nx]   = v ? d : 0;   // R7: an invalid slot counts as zero
    nx++;
  endtask

  task automatic run_stream(input logic [3:0] code, input int nsamp, input int pat,
                            input int amp, input int ncyc, input string tag);
    int kind;
    kind = (code == 4'h1) ? 1 : (code == 4'h5) ? 2 : 0;
    @(negedge clk);
    in_valid  = 1'b0;
    mode_code = code;
    #1;
    chk("R10", int'(in_ready), 0);
    @(negedge clk);
    chk("R10", s12(dac_data), 0);
    chk("R6", int'(in_ready), 1);
    nx = 0;
    drive(pat, amp);
    for (int t = 0; t < ncyc; t++) begin
      string rq;
      @(negedge clk);
      rq = tag;
      if (pat == 0 && t == 30)      rq = "R4";
      else if (pat == 0 && t >= 48) rq = "R5";
      chk(rq, s12(dac_data), ref_out(t, kind));
      chk("R6", int'(in_ready), (kind == 0) ? 1 : (t % 2));
      if (in_ready) begin
        if (nx < nsamp) drive(pat, amp);
        else            in_valid = 1'b0;
      end
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1", s12(dac_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", s12(dac_data), 0);
    chk("R1", int'(in_ready), 1);
  endtask

  task automatic test_lpf_impulse();
    run_stream(4'h1, 26, 0, 1000, 60, "R2");
  endtask

  task automatic test_bpf_impulse();
    run_stream(4'h5, 26, 0, -700, 60, "R3");
  endtask

  task automatic test_lpf_stream();
    run_stream(4'h1, 40, 1, 0, 80, "R2");
  endtask

  task automatic test_pass();
    run_stream(4'h0, 30, 1, 0, 36, "R9");
  endtask

  task automatic test_saturation();
    run_stream(4'h1, 36, 2, 0, 80, "R8");
  endtask

  task automatic test_gaps();
    run_stream(4'h5, 36, 3, 0, 80, "R7");
  endtask

  task automatic test_other_code();
    run_stream(4'h9, 30, 2, 0, 36, "R9");
  endtask

  task automatic test_bpf_drain();
    run_stream(4'h5, 30, 1, 0, 110, "R3");
  endtask

  initial begin
    test_reset();
    test_lpf_impulse();
    test_bpf_impulse();
    test_lpf_stream();
    test_pass();
    test_saturation();
    test_gaps();
    test_other_code();
    test_bpf_drain();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule